// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the beam timing for a raster display. A fine-pixel sub-counter, a coarse horizontal counter and a line counter advance on a pixel-clock enable. The block decodes the sync pulses, the blanking intervals, a composite sync, an odd/even field flag and a one-cycle start-of-frame pulse from those counters. Every timing value comes from a register that software writes through a simple synchronous write port. Horizontal registers count coarse units of eight fine pixels. Vertical registers count scanlines. The horizontal and vertical totals hold the last counter value, not the period.

Writes land in a shadow set. The shadow set is copied into the active set at the instant the beam wraps to the origin of a new frame, so a frame never mixes old and new timing. Blanking windows are programmed separately from sync windows. A window whose start lies above its stop wraps around the line or frame end. In interlaced operation, the odd field moves both vertical sync edges to a programmable mid-line position. Each sync output has its own polarity bit. An optional mode makes successive lines alternate between a short and a long length.

Top module: `raster_sync_gen`

## Requirements
- R1: On each cycle with `pix_en` high, the fine count (0..7) advances. At fine 7 the coarse count advances. A short line wraps the coarse count after the value htotal. The line count wraps after vtotal. `h_pos` is coarse*8+fine and `v_pos` is the line.
- R2: The internal hsync term is asserted while the coarse count lies in the window [hsync start, hsync stop). If start is greater than stop, the window is count >= start OR count < stop. If start equals stop, the window is empty. The `hsync` pin equals the term when control bit 1 is 1 and its inverse when control bit 1 is 0.
- R3: `hblank` (coarse count) and `vblank` (line count) are asserted over their own windows, using the same window rule as R2. They are active-high and independent of the sync registers.
- R4: The vsync term uses the position line*2+h, where h is 1 once the coarse count is at or above the mid-line register. The window runs from vsync start*2+o to vsync stop*2+o, with o = 1 only in the odd field of an interlaced frame. The `vsync` pin is the term when control bit 2 is 1 and its inverse otherwise.
- R5: Control bit 0 at 1 makes every line htotal+1 coarse units long. Control bit 0 at 0 makes lines alternate between short (htotal+1) and long (htotal+2) units, and the first line of each frame is short.
- R6: The composite term is asserted when exactly one of the hsync and vsync terms is asserted. The `csync` pin is the term when control bit 3 is 1 and its inverse otherwise.
- R7: Writes update the shadow registers. The register addresses are: 0 htotal, 1 hsync start, 2 hsync stop, 3 hblank start, 4 hblank stop, 5 mid-line, 6 vtotal, 7 vsync start, 8 vsync stop, 9 vblank start, 10 vblank stop, 11 control. Addresses 12..15 are ignored. The active set takes the shadow contents only on the frame-wrap cycle, and the `interlace` input is captured the same way.
- R8: `sof` is high for exactly the one cycle after the frame-wrap cycle.
- R9: At each frame wrap, `field` toggles if interlace was enabled for the new frame and is cleared to 0 if it was not. It does not change at any other time.
- R10: After synchronous reset, the counters, `field` and `sof` are 0, and the active and shadow sets hold the parameter reset values.
- R11: While `pix_en` is low, the counters, `field` and all decoded outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Fine pixel advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data (low bits used) |
| interlace | input | 1 | Interlace request, applied at frame wrap |
| h_pos | output | 11 | Horizontal beam position in fine pixels |
| v_pos | output | 10 | Line number |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| vsync | output | 1 | Vertical sync, programmable polarity |
| csync | output | 1 | Composite sync, programmable polarity |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| field | output | 1 | Field flag (1 = odd) |
| sof | output | 1 | Start-of-frame pulse |

## Verification
The bench targets these corner cases:

- **Writes in mid-frame.** A design that applied a write at once would tear the frame.
- **Writes to unused addresses.** A design that decoded them loosely would corrupt a timing register.
- **Blank windows that wrap.** A plain range compare would lose such a window.
- **The odd-field mid-line vsync edges.** A design that moved only one edge, or moved them in the even field, would put them in the wrong place.
- **Long/short line alternation.** Frame length is measured from `sof` to `sof` with the alternation on and off. An off-by-one in the line-length selection, or a failure to restart each frame with a short line, changes the count.
- **Enable-low gaps.** A design that did not hold everything while `pix_en` is low would drift.
- **Interlace turned off.** A design that kept toggling the field flag would fail.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    localparam int HW    = 8;          // coarse horizontal counter width
    localparam int VW    = 10;         // line counter width
    localparam int FW    = 3;          // fine pixels per coarse unit = 2**FW
    localparam int DW    = 16;         // write data width
    localparam int AW    = 4;          // register address width
    localparam int WIN_W = VW + 1;     // widest window comparison (line + half)
    localparam int NREGS = 12;

    typedef enum logic [AW-1:0] {
        A_HTOTAL = 4'd0,
        A_HS_ON  = 4'd1,
        A_HS_OFF = 4'd2,
        A_HB_ON  = 4'd3,
        A_HB_OFF = 4'd4,
        A_HMID   = 4'd5,
        A_VTOTAL = 4'd6,
        A_VS_ON  = 4'd7,
        A_VS_OFF = 4'd8,
        A_VB_ON  = 4'd9,
        A_VB_OFF = 4'd10,
        A_CTRL   = 4'd11
    } reg_addr_e;

    typedef struct packed {
        logic cs_hi;     // bit 3
        logic vs_hi;     // bit 2
        logic hs_hi;     // bit 1
        logic alt_off;   // bit 0
    } ctrl_t;

    typedef struct packed {
        logic [HW-1:0] h_last;
        logic [HW-1:0] hs_on;
        logic [HW-1:0] hs_off;
        logic [HW-1:0] hb_on;
        logic [HW-1:0] hb_off;
        logic [HW-1:0] h_mid;
        logic [VW-1:0] v_last;
        logic [VW-1:0] vs_on;
        logic [VW-1:0] vs_off;
        logic [VW-1:0] vb_on;
        logic [VW-1:0] vb_off;
        ctrl_t         ctrl;
    } timing_t;

    typedef struct packed {
        logic [HW-1:0] coarse;
        logic [FW-1:0] fine;
        logic [VW-1:0] line;
        logic          field;
        logic          long_line;
    } beam_t;

    // Half-open window test; start > stop wraps, start == stop is empty.
    function automatic logic in_window(logic [WIN_W-1:0] pos,
                                       logic [WIN_W-1:0] start,
                                       logic [WIN_W-1:0] stop);
        if (start <= stop)
            return (pos >= start) && (pos < stop);
        return (pos >= start) || (pos < stop);
    endfunction

    function automatic timing_t apply_write(timing_t cur,
                                            logic [AW-1:0] addr,
                                            logic [DW-1:0] data);
        timing_t nxt;
        nxt = cur;
        case (reg_addr_e'(addr))
            A_HTOTAL: nxt.h_last = data[HW-1:0];
            A_HS_ON:  nxt.hs_on  = data[HW-1:0];
            A_HS_OFF: nxt.hs_off = data[HW-1:0];
            A_HB_ON:  nxt.hb_on  = data[HW-1:0];
            A_HB_OFF: nxt.hb_off = data[HW-1:0];
            A_HMID:   nxt.h_mid  = data[HW-1:0];
            A_VTOTAL: nxt.v_last = data[VW-1:0];
            A_VS_ON:  nxt.vs_on  = data[VW-1:0];
            A_VS_OFF: nxt.vs_off = data[VW-1:0];
            A_VB_ON:  nxt.vb_on  = data[VW-1:0];
            A_VB_OFF: nxt.vb_off = data[VW-1:0];
            A_CTRL:   nxt.ctrl   = ctrl_t'(data[3:0]);
            default:  ;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rsg_regs.sv
module rsg_regs
    import rsg_pkg::*;
#(
    parameter timing_t RST_CFG = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          interlace,
    input  logic          load,
    output timing_t       act_cfg,
    output logic          act_il,
    output logic          next_il
);

    timing_t shadow_cfg;
    logic    shadow_il;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_cfg <= RST_CFG;
            act_cfg    <= RST_CFG;
            shadow_il  <= 1'b0;
            act_il     <= 1'b0;
        end else begin
            if (wr_en)
                shadow_cfg <= apply_write(shadow_cfg, wr_addr, wr_data);
            shadow_il <= interlace;
            if (load) begin
                act_cfg <= shadow_cfg;
                act_il  <= shadow_il;
            end
        end
    end

    assign next_il = shadow_il;

endmodule

// File: rtl/rsg_beam.sv
module rsg_beam
    import rsg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pix_en,
    input  timing_t act_cfg,
    input  logic    next_il,
    output beam_t   beam,
    output logic    wrap,
    output logic    sof
);

    localparam logic [FW-1:0] FINE_MAX = '1;

    logic [HW-1:0] line_last;
    logic          fine_end;
    logic          line_end;

    assign line_last = beam.long_line ? act_cfg.h_last + HW'(1) : act_cfg.h_last;
    assign fine_end  = pix_en && (beam.fine == FINE_MAX);
    assign line_end  = fine_end && (beam.coarse == line_last);
    assign wrap      = line_end && (beam.line == act_cfg.v_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            beam <= '0;
            sof  <= 1'b0;
        end else begin
            sof <= wrap;
            if (pix_en) begin
                if (fine_end) begin
                    beam.fine <= '0;
                    if (line_end) begin
                        beam.coarse <= '0;
                        if (wrap) begin
                            beam.line      <= '0;
                            beam.long_line <= 1'b0;
                            beam.field     <= next_il ? ~beam.field : 1'b0;
                        end else begin
                            beam.line      <= beam.line + VW'(1);
                            beam.long_line <= act_cfg.ctrl.alt_off ? 1'b0 : ~beam.long_line;
                        end
                    end else begin
                        beam.coarse <= beam.coarse + HW'(1);
                    end
                end else begin
                    beam.fine <= beam.fine + FW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rsg_decode.sv
module rsg_decode
    import rsg_pkg::*;
(
    input  timing_t act_cfg,
    input  logic    act_il,
    input  beam_t   beam,
    output logic    hsync,
    output logic    vsync,
    output logic    csync,
    output logic    hblank,
    output logic    vblank
);

    localparam int NSYNC = 3;

    logic             past_mid;
    logic             odd_shift;
    logic             hs_term;
    logic             vs_term;
    logic [NSYNC-1:0] term;
    logic [NSYNC-1:0] pol_hi;
    logic [NSYNC-1:0] level;

    assign past_mid  = beam.coarse >= act_cfg.h_mid;
    assign odd_shift = act_il & beam.field;

    assign hs_term = in_window(WIN_W'(beam.coarse), WIN_W'(act_cfg.hs_on), WIN_W'(act_cfg.hs_off));
    assign vs_term = in_window({beam.line, past_mid},
                               {act_cfg.vs_on, odd_shift},
                               {act_cfg.vs_off, odd_shift});

    assign hblank = in_window(WIN_W'(beam.coarse), WIN_W'(act_cfg.hb_on), WIN_W'(act_cfg.hb_off));
    assign vblank = in_window(WIN_W'(beam.line), WIN_W'(act_cfg.vb_on), WIN_W'(act_cfg.vb_off));

    assign term   = {hs_term ^ vs_term, vs_term, hs_term};
    assign pol_hi = {act_cfg.ctrl.cs_hi, act_cfg.ctrl.vs_hi, act_cfg.ctrl.hs_hi};

    for (genvar i = 0; i < NSYNC; i++) begin : g_pol
        assign level[i] = pol_hi[i] ? term[i] : ~term[i];
    end

    assign hsync = level[0];
    assign vsync = level[1];
    assign csync = level[2];

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import rsg_pkg::*;
#(
    parameter int RST_HTOTAL = 14,
    parameter int RST_HS_ON  = 1,
    parameter int RST_HS_OFF = 3,
    parameter int RST_HB_ON  = 12,
    parameter int RST_HB_OFF = 2,
    parameter int RST_HMID   = 7,
    parameter int RST_VTOTAL = 9,
    parameter int RST_VS_ON  = 1,
    parameter int RST_VS_OFF = 2,
    parameter int RST_VB_ON  = 8,
    parameter int RST_VB_OFF = 1,
    parameter int RST_CTRL   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             interlace,
    output logic [HW+FW-1:0] h_pos,
    output logic [VW-1:0]    v_pos,
    output logic             hsync,
    output logic             vsync,
    output logic             csync,
    output logic             hblank,
    output logic             vblank,
    output logic             field,
    output logic             sof
);

    localparam timing_t RST_CFG = '{
        h_last: HW'(RST_HTOTAL),
        hs_on:  HW'(RST_HS_ON),
        hs_off: HW'(RST_HS_OFF),
        hb_on:  HW'(RST_HB_ON),
        hb_off: HW'(RST_HB_OFF),
        h_mid:  HW'(RST_HMID),
        v_last: VW'(RST_VTOTAL),
        vs_on:  VW'(RST_VS_ON),
        vs_off: VW'(RST_VS_OFF),
        vb_on:  VW'(RST_VB_ON),
        vb_off: VW'(RST_VB_OFF),
        ctrl:   ctrl_t'(4'(RST_CTRL))
    };

    timing_t act_cfg;
    logic    act_il;
    logic    next_il;
    beam_t   beam;
    logic    frame_wrap;

    rsg_regs #(.RST_CFG(RST_CFG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .interlace (interlace),
        .load      (frame_wrap),
        .act_cfg   (act_cfg),
        .act_il    (act_il),
        .next_il   (next_il)
    );

    rsg_beam u_beam (
        .clk     (clk),
        .rst     (rst),
        .pix_en  (pix_en),
        .act_cfg (act_cfg),
        .next_il (next_il),
        .beam    (beam),
        .wrap    (frame_wrap),
        .sof     (sof)
    );

    rsg_decode u_decode (
        .act_cfg (act_cfg),
        .act_il  (act_il),
        .beam    (beam),
        .hsync   (hsync),
        .vsync   (vsync),
        .csync   (csync),
        .hblank  (hblank),
        .vblank  (vblank)
    );

    assign h_pos = {beam.coarse, beam.fine};
    assign v_pos = beam.line;
    assign field = beam.field;

endmodule

// File: rtl/raster_sync_gen_chk.sv
module raster_sync_gen_chk
    import rsg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pix_en,
    input logic [HW+FW-1:0] h_pos,
    input logic [VW-1:0]    v_pos,
    input logic             hsync,
    input logic             vsync,
    input logic             csync,
    input logic             field,
    input logic             sof,
    input logic             wrap,
    input timing_t          act
);

    assert_hpos_bound_R1: assert property (@(posedge clk) disable iff (rst)
        {1'b0, h_pos[HW+FW-1:FW]} <= ({1'b0, act.h_last} + (HW+1)'(1)));

    assert_vpos_bound_R1: assert property (@(posedge clk) disable iff (rst)
        v_pos <= act.v_last);

    assert_csync_term_R6: assert property (@(posedge clk) disable iff (rst)
        ((csync == act.ctrl.cs_hi) ==
         ((hsync == act.ctrl.hs_hi) ^ (vsync == act.ctrl.vs_hi))));

    assert_active_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act));

    assert_sof_follows_R8: assert property (@(posedge clk) disable iff (rst)
        wrap |=> sof);

    assert_sof_single_R8: assert property (@(posedge clk) disable iff (rst)
        sof |=> !sof);

    assert_field_at_frame_R9: assert property (@(posedge clk) disable iff (rst)
        (field != $past(field)) |-> sof);

    assert_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(h_pos) && $stable(v_pos) && $stable(field)));

endmodule

bind raster_sync_gen raster_sync_gen_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pix_en (pix_en),
    .h_pos  (h_pos),
    .v_pos  (v_pos),
    .hsync  (hsync),
    .vsync  (vsync),
    .csync  (csync),
    .field  (field),
    .sof    (sof),
    .wrap   (frame_wrap),
    .act    (act_cfg)
);

// File: tb/raster_sync_gen_tb.sv
module raster_sync_gen_tb;
    import rsg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 190000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pix_en = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [DW-1:0]    wr_data = '0;
    logic             interlace = 1'b0;
    logic [HW+FW-1:0] h_pos;
    logic [VW-1:0]    v_pos;
    logic             hsync, vsync, csync, hblank, vblank, field, sof;

    raster_sync_gen u_dut (
        .clk(clk), .rst(rst), .pix_en(pix_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .interlace(interlace), .h_pos(h_pos), .v_pos(v_pos),
        .hsync(hsync), .vsync(vsync), .csync(csync), .hblank(hblank),
        .vblank(vblank), .field(field), .sof(sof)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int rst_vals[NREGS] = '{14, 1, 3, 12, 2, 7, 9, 1, 2, 8, 1, 1};
    int m_sh[NREGS];
    int m_ac[NREGS];
    int m_il_sh, m_il_ac, m_fine, m_hc, m_vc, m_field, m_long, m_sof;

    function automatic int reg_mask(int a);
        if (a <= 5) return 255;
        if (a <= 10) return 1023;
        return 15;
    endfunction

    function automatic int win(int p, int s, int e);
        if (s <= e) return int'(p >= s && p < e);
        return int'(p >= s || p < e);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(bit r, bit pe, bit we, int a, int d, bit il);
        if (r) begin
            for (int i = 0; i < NREGS; i++) begin
                m_sh[i] = rst_vals[i];
                m_ac[i] = rst_vals[i];
            end
            m_il_sh = 0; m_il_ac = 0; m_fine = 0; m_hc = 0; m_vc = 0;
            m_field = 0; m_long = 0; m_sof = 0;
        end else begin
            int last, wrap;
            last = m_long ? ((m_ac[0] + 1) & 255) : m_ac[0];
            wrap = int'(pe && m_fine == 7 && m_hc == last && m_vc == m_ac[6]);
            if (pe) begin
                if (m_fine == 7) begin
                    m_fine = 0;
                    if (m_hc == last) begin
                        m_hc = 0;
                        if (wrap != 0) begin
                            m_vc = 0;
                            m_long = 0;
                            m_field = m_il_sh ? 1 - m_field : 0;
                        end else begin
                            m_vc = m_vc + 1;
                            m_long = (m_ac[11] & 1) ? 0 : 1 - m_long;
                        end
                    end else m_hc = m_hc + 1;
                end else m_fine = m_fine + 1;
            end
            if (wrap != 0) begin
                for (int i = 0; i < NREGS; i++) m_ac[i] = m_sh[i];
                m_il_ac = m_il_sh;
            end
            m_il_sh = il;
            if (we && a < NREGS) m_sh[a] = d & reg_mask(a);
            m_sof = wrap;
        end
    endtask

    task automatic compare_all();
        int hs, vs, hb, vb, cs, half, odd, c;
        c    = m_ac[11];
        hs   = win(m_hc, m_ac[1], m_ac[2]);
        hb   = win(m_hc, m_ac[3], m_ac[4]);
        half = int'(m_hc >= m_ac[5]);
        odd  = int'(m_il_ac != 0 && m_field != 0);
        vs   = win(m_vc * 2 + half, m_ac[7] * 2 + odd, m_ac[8] * 2 + odd);
        vb   = win(m_vc, m_ac[9], m_ac[10]);
        cs   = hs ^ vs;
        check("R1 h_pos", int'(h_pos), m_hc * 8 + m_fine);
        check("R1 v_pos", int'(v_pos), m_vc);
        check("R2 hsync", int'(hsync), ((c >> 1) & 1) ? hs : 1 - hs);
        check("R3 hblank", int'(hblank), hb);
        check("R3 vblank", int'(vblank), vb);
        check("R4 vsync", int'(vsync), ((c >> 2) & 1) ? vs : 1 - vs);
        check("R6 csync", int'(csync), ((c >> 3) & 1) ? cs : 1 - cs);
        check("R8 sof", int'(sof), m_sof);
        check("R9 field", int'(field), m_field);
    endtask

    task automatic cyc(bit pe, bit we, int a, int d);
        pix_en  = pe;
        wr_en   = we;
        wr_addr = AW'(a);
        wr_data = DW'(d);
        model_step(rst, pe, we, a, d, interlace);
        @(negedge clk);
        compare_all();
    endtask

    task automatic write_cfg(int ht, int vt, int ctrl);
        cyc(1'b1, 1'b1, 0, ht);
        cyc(1'b1, 1'b1, 6, vt);
        cyc(1'b1, 1'b1, 11, ctrl);
    endtask

    task automatic measure_frame(output int n);
        n = 0;
        while (sof !== 1'b1) cyc(1'b1, 1'b0, 0, 0);
        do begin
            cyc(1'b1, 1'b0, 0, 0);
            n++;
        end while (sof !== 1'b1);
    endtask

    initial begin
        int n, seed, f0, ht, vt;
        seed = $urandom(32'h5eed);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) cyc(1'b0, 1'b0, 0, 0);
        rst = 1'b0;
        // R10: reset state
        check("R10 h_pos after reset", int'(h_pos), 0);
        check("R10 v_pos after reset", int'(v_pos), 0);
        check("R10 sof after reset", int'(sof), 0);
        check("R10 field after reset", int'(field), 0);

        // R11: enable low holds everything
        repeat (20) cyc(1'b1, 1'b0, 0, 0);
        n = int'(h_pos);
        repeat (15) cyc(1'b0, 1'b0, 0, 0);
        check("R11 h_pos frozen", int'(h_pos), n);

        // R5: alternation on, htotal 10, vtotal 5 -> 3*11+3*12 units of 8 cycles
        write_cfg(10, 5, 0);
        measure_frame(n);
        measure_frame(n);
        check("R5 frame length alternating", n, 552);
        // R5: alternation off -> 6*11 units
        write_cfg(10, 5, 1);
        measure_frame(n);
        measure_frame(n);
        check("R5 frame length fixed", n, 528);

        // R7: writes to unused addresses leave the frame length unchanged
        cyc(1'b1, 1'b1, 12, 3);
        cyc(1'b1, 1'b1, 14, 3);
        cyc(1'b1, 1'b1, 15, 3);
        measure_frame(n);
        measure_frame(n);
        check("R7 unused address ignored", n, 528);

        // R7: mid-frame write not visible before the wrap
        while (v_pos != 2) cyc(1'b1, 1'b0, 0, 0);
        cyc(1'b1, 1'b1, 6, 3);
        repeat (40) cyc(1'b1, 1'b0, 0, 0);
        check("R7 shadow not applied mid-frame", int'(v_pos) >= 2 ? 1 : 0, 1);

        // R9: field toggles each frame with interlace, with odd-field vsync shift (R4)
        interlace = 1'b1;
        cyc(1'b1, 1'b1, 5, 4);
        cyc(1'b1, 1'b1, 7, 1);
        cyc(1'b1, 1'b1, 8, 2);
        measure_frame(n);
        f0 = int'(field);
        measure_frame(n);
        check("R9 field toggles with interlace", int'(field), 1 - f0);
        interlace = 1'b0;
        measure_frame(n);
        measure_frame(n);
        check("R9 field cleared without interlace", int'(field), 0);

        // constrained random configurations with random enable and scattered writes
        for (int it = 0; it < 24; it++) begin
            ht = 8 + int'($urandom % 10);
            vt = 4 + int'($urandom % 6);
            if ($urandom % 3 == 0) interlace = ~interlace;
            for (int k = 0; k < 2600; k++) begin
                bit pe, we;
                int a, d;
                pe = ($urandom % 8) != 0;
                we = ($urandom % 40) == 0;
                a  = int'($urandom % 16);
                if (a == 0) d = ht;
                else if (a == 6) d = vt;
                else if (a <= 5) d = int'($urandom % (ht + 2));
                else if (a <= 10) d = int'($urandom % (vt + 1));
                else if (a == 11) d = int'($urandom % 16);
                else d = int'($urandom % 4);
                if (k == 0) begin we = 1'b1; a = 0; d = ht; end
                if (k == 1) begin we = 1'b1; a = 6; d = vt; end
                cyc(pe, we, a, d);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule